// File: doc/BRIEF.md
# SD Command Path Sequencer

This block runs one host-side command transaction on an SD/SDIO command line. On the system clock it takes a command request and latches four options with it: response expected, interrupt wait, hold for a data-path trigger, and completion-signal handling. It then pulses a start strobe to an external command serializer. After that it follows the serializer, response and CRC handshake inputs until the transaction ends.

A single-cycle card-clock enable strobe drives both counters. One is a response timeout of 64 strobes. The other is an idle gap of 8 strobes that must pass before the next command may start. Results are kept as sticky flags: timeout, CRC failure and response received. A busy output is high whenever a transaction is in progress. Dropping the enable input abandons the transaction at once and raises no flag.

Top module: `sd_cmd_sequencer`

## Requirements
- R1: After reset the block is idle: busy, ser_start and all three flags are 0.
- R2: In idle, with enable high, cmd_valid high and the idle gap complete, the block starts a transaction. busy goes high and ser_start pulses for exactly one cycle.
- R3: A command with cmd_pend set does not pulse ser_start until data_trig arrives. ser_start pulses on the cycle after data_trig.
- R4: After ser_done, a command without cmd_resp returns to idle with no flag set. A command with cmd_resp waits for a response.
- R5: While waiting for a response (interrupt wait off), the 64th card-clock strobe without rsp_start sets to_flag and returns to idle. If rsp_start comes first, the timeout is cancelled.
- R6: With cmd_irq set, no timeout occurs. The block stays busy until card_irq, then returns to idle.
- R7: While receiving, crc_fail sets crc_flag and returns to idle without setting rsp_flag. rsp_done sets rsp_flag.
- R8: On rsp_done with cmd_cpl_mode and cmd_cpl_wait both set (and cmd_irq clear), the block stays busy until cpl_sig or crc_fail. Otherwise it goes idle.
- R9: A new command starts no sooner than 8 card-clock strobes after idle is entered, including after reset.
- R10: Both counters advance only on cycles where ck_stb is high.
- R11: enable low forces idle on the next cycle and sets no flag.
- R12: Flags stay set until a flag_clr pulse. A flag that is being set in the same cycle as flag_clr stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Sequencer enable; low aborts |
| ck_stb | input | 1 | One-cycle card-clock strobe |
| cmd_valid | input | 1 | Command request |
| cmd_resp | input | 1 | Response expected |
| cmd_irq | input | 1 | Wait for card interrupt, no timeout |
| cmd_pend | input | 1 | Hold until data-path trigger |
| cmd_cpl_mode | input | 1 | Completion-signal mode |
| cmd_cpl_wait | input | 1 | Wait for completion signal after response |
| data_trig | input | 1 | Data-path trigger pulse |
| ser_done | input | 1 | Serializer finished sending |
| rsp_start | input | 1 | Response start bit seen |
| rsp_done | input | 1 | Response fully received |
| crc_fail | input | 1 | Response CRC mismatch |
| card_irq | input | 1 | Card interrupt request |
| cpl_sig | input | 1 | Completion signal from card |
| flag_clr | input | 1 | Clear sticky flags |
| ser_start | output | 1 | Serializer start pulse |
| busy | output | 1 | Transaction in progress |
| to_flag | output | 1 | Sticky response timeout |
| crc_flag | output | 1 | Sticky CRC failure |
| rsp_flag | output | 1 | Sticky response received |

## Verification
The assertions assume the following about the inputs:
- Handshake inputs (ser_done, rsp_start, rsp_done, crc_fail, cpl_sig, data_trig, card_irq) are single-cycle pulses.
- Each pulse arrives only in the phase of the transaction that uses it.
- flag_clr is a one-cycle pulse.

The stimulus follows these rules. It drives every handshake pulse for one cycle at a falling edge. It raises each pulse only after busy confirms a transaction is active. It changes the strobe divider only while the block is idle, so timing checks can count strobes against fixed limits.

// File: rtl/sd_cmd_sequencer.sv
module sd_cmd_sequencer #(
  parameter int TMO_TICKS = 64,
  parameter int GAP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ck_stb,
  input  logic cmd_valid,
  input  logic cmd_resp,
  input  logic cmd_irq,
  input  logic cmd_pend,
  input  logic cmd_cpl_mode,
  input  logic cmd_cpl_wait,
  input  logic data_trig,
  input  logic ser_done,
  input  logic rsp_start,
  input  logic rsp_done,
  input  logic crc_fail,
  input  logic card_irq,
  input  logic cpl_sig,
  input  logic flag_clr,
  output logic ser_start,
  output logic busy,
  output logic to_flag,
  output logic crc_flag,
  output logic rsp_flag
);
  localparam int TW = $clog2(TMO_TICKS + 1);
  localparam int GW = $clog2(GAP_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_SEND, S_WAIT, S_RECV, S_WCPL} state_t;

  state_t state, nxt;
  logic [TW-1:0] tmo;
  logic [GW-1:0] gap;
  logic f_resp, f_irq, f_cplm, f_cplw;
  logic set_to, set_crc, set_rsp;

  wire gap_done = (gap == GW'(GAP_TICKS));
  wire tmo_hit  = ck_stb && !f_irq && (tmo == TW'(TMO_TICKS - 1));

  assign busy = (state != S_IDLE);

  always_comb begin
    nxt     = state;
    set_to  = 1'b0;
    set_crc = 1'b0;
    set_rsp = 1'b0;
    if (!enable) nxt = S_IDLE;
    else begin
      case (state)
        S_IDLE: if (cmd_valid && gap_done) nxt = cmd_pend ? S_PEND : S_SEND;
        S_PEND: if (data_trig) nxt = S_SEND;
        S_SEND: if (ser_done) nxt = f_resp ? S_WAIT : S_IDLE;
        S_WAIT: begin
          if (f_irq) begin
            if (card_irq) nxt = S_IDLE;
          end else if (rsp_start) nxt = S_RECV;
          else if (tmo_hit) begin
            set_to = 1'b1;
            nxt    = S_IDLE;
          end
        end
        S_RECV: begin
          if (crc_fail) begin
            set_crc = 1'b1;
            nxt     = S_IDLE;
          end else if (rsp_done) begin
            set_rsp = 1'b1;
            nxt     = (f_cplm && !f_irq && f_cplw) ? S_WCPL : S_IDLE;
          end
        end
        S_WCPL: begin
          if (crc_fail) begin
            set_crc = 1'b1;
            nxt     = S_IDLE;
          end else if (cpl_sig) nxt = S_IDLE;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ser_start <= 1'b0;
      tmo       <= '0;
      gap       <= '0;
      f_resp    <= 1'b0;
      f_irq     <= 1'b0;
      f_cplm    <= 1'b0;
      f_cplw    <= 1'b0;
      to_flag   <= 1'b0;
      crc_flag  <= 1'b0;
      rsp_flag  <= 1'b0;
    end else begin
      state     <= nxt;
      ser_start <= (nxt == S_SEND) && (state != S_SEND);
      if (state == S_IDLE && nxt != S_IDLE) begin
        f_resp <= cmd_resp;
        f_irq  <= cmd_irq;
        f_cplm <= cmd_cpl_mode;
        f_cplw <= cmd_cpl_wait;
      end
      if (state != S_WAIT) tmo <= '0;
      else if (ck_stb && !f_irq) tmo <= tmo + 1'b1;
      if (state != S_IDLE) gap <= '0;
      else if (ck_stb && !gap_done) gap <= gap + 1'b1;
      to_flag  <= set_to  | (to_flag  & ~flag_clr);
      crc_flag <= set_crc | (crc_flag & ~flag_clr);
      rsp_flag <= set_rsp | (rsp_flag & ~flag_clr);
    end
  end
endmodule

// File: rtl/sd_cmd_sequencer_chk.sv
module sd_cmd_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic flag_clr,
  input logic ser_start,
  input logic busy,
  input logic to_flag,
  input logic crc_flag,
  input logic rsp_flag,
  input logic gap_done
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> !ser_start);

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  assert_gap_before_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(gap_done));

  assert_timeout_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> ($past(busy) && !busy));

  assert_crc_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_flag) |-> !busy);

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_flag && !flag_clr) |=> rsp_flag);
endmodule

bind sd_cmd_sequencer sd_cmd_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
  .ser_start(ser_start), .busy(busy), .to_flag(to_flag),
  .crc_flag(crc_flag), .rsp_flag(rsp_flag), .gap_done(gap_done)
);

// File: tb/sd_cmd_sequencer_test.sv
module sd_cmd_sequencer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, ck_stb = 1'b0, cmd_valid = 1'b0;
  logic cmd_resp = 1'b0, cmd_irq = 1'b0, cmd_pend = 1'b0;
  logic cmd_cpl_mode = 1'b0, cmd_cpl_wait = 1'b0;
  logic data_trig = 1'b0, ser_done = 1'b0, rsp_start = 1'b0, rsp_done = 1'b0;
  logic crc_fail = 1'b0, card_irq = 1'b0, cpl_sig = 1'b0, flag_clr = 1'b0;
  logic ser_start, busy, to_flag, crc_flag, rsp_flag;

  int checks = 0, fails = 0;
  int div = 1, phase = 0;
  int stb_cnt = 0, cycles = 0;
  bit saw_start;

  sd_cmd_sequencer uut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    phase  = (phase >= div - 1) ? 0 : phase + 1;
    ck_stb = (phase == 0);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (ck_stb) stb_cnt <= stb_cnt + 1;
  end

  always @(posedge clk) if (cycles > 150000) begin
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input bit resp, input bit irq, input bit pend, input bit cm, input bit cw);
    cmd_resp = resp; cmd_irq = irq; cmd_pend = pend;
    cmd_cpl_mode = cm; cmd_cpl_wait = cw;
    enable = 1'b1; cmd_valid = 1'b1;
    for (int i = 0; i < 500 && !busy; i++) @(negedge clk);
    cmd_valid = 1'b0;
    saw_start = ser_start;
  endtask

  task automatic t_reset_and_gap();
    int base;
    chk(!busy && !ser_start, "R1 idle after reset", busy, 0);
    chk(!to_flag && !crc_flag && !rsp_flag, "R1 flags clear", {to_flag, crc_flag, rsp_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1; enable = 1'b1; cmd_valid = 1'b1; cmd_resp = 1'b0;
    base = stb_cnt;
    for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
    cmd_valid = 1'b0;
    chk(stb_cnt - base == 9, "R9 gap after reset", stb_cnt - base, 9);
    chk(ser_start && busy, "R2 start pulse", ser_start, 1);
    @(negedge clk);
    chk(!ser_start, "R2 single pulse", ser_start, 0);
    pulse(ser_done);
    chk(!busy && !to_flag && !rsp_flag, "R4 no response goes idle", busy, 0);
  endtask

  task automatic t_response();
    idle_wait(12);
    issue(1, 0, 0, 0, 0);
    pulse(ser_done);
    idle_wait(5);
    chk(busy, "R4 waiting for response", busy, 1);
    pulse(rsp_start);
    pulse(rsp_done);
    chk(!busy && rsp_flag && !to_flag, "R7 response received", rsp_flag, 1);
    pulse(flag_clr);
    chk(!rsp_flag, "R12 clear", rsp_flag, 0);
  endtask

  task automatic t_timeout();
    int base;
    idle_wait(12);
    div = 3;
    issue(1, 0, 0, 0, 0);
    pulse(ser_done);
    base = stb_cnt;
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    chk(stb_cnt - base == 64, "R5 R10 timeout after 64 strobes", stb_cnt - base, 64);
    chk(to_flag, "R5 timeout flag", to_flag, 1);
    idle_wait(5);
    chk(to_flag, "R12 sticky", to_flag, 1);
    pulse(flag_clr);
    chk(!to_flag, "R12 clear timeout", to_flag, 0);
    idle_wait(40);
    div = 1;
  endtask

  task automatic t_irq_wait();
    idle_wait(12);
    issue(1, 1, 0, 0, 0);
    pulse(ser_done);
    idle_wait(150);
    chk(busy && !to_flag, "R6 no timeout in irq wait", busy, 1);
    pulse(card_irq);
    chk(!busy && !to_flag, "R6 irq ends wait", busy, 0);
  endtask

  task automatic t_pend();
    idle_wait(12);
    issue(0, 0, 1, 0, 0);
    chk(!saw_start && busy, "R3 no start while pending", saw_start, 0);
    idle_wait(10);
    chk(!ser_start && busy, "R3 still pending", ser_start, 0);
    pulse(data_trig);
    chk(ser_start, "R3 start after trigger", ser_start, 1);
    pulse(ser_done);
    chk(!busy, "R4 idle after pended send", busy, 0);
  endtask

  task automatic t_crc();
    idle_wait(12);
    issue(1, 0, 0, 0, 0);
    pulse(ser_done);
    pulse(rsp_start);
    crc_fail = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    crc_fail = 1'b0; flag_clr = 1'b0;
    chk(crc_flag && !busy && !rsp_flag, "R7 R12 crc fail wins over clear", crc_flag, 1);
    pulse(flag_clr);
  endtask

  task automatic t_cpl();
    idle_wait(12);
    issue(1, 0, 0, 1, 1);
    pulse(ser_done);
    pulse(rsp_start);
    pulse(rsp_done);
    idle_wait(10);
    chk(busy && rsp_flag, "R8 waiting for completion", busy, 1);
    pulse(cpl_sig);
    chk(!busy, "R8 completion ends", busy, 0);
    idle_wait(12);
    issue(1, 0, 0, 1, 0);
    pulse(ser_done);
    pulse(rsp_start);
    pulse(rsp_done);
    chk(!busy, "R8 completion wait disabled", busy, 0);
    pulse(flag_clr);
  endtask

  task automatic t_abort();
    idle_wait(12);
    issue(1, 0, 0, 0, 0);
    pulse(ser_done);
    enable = 1'b0;
    @(negedge clk);
    chk(!busy && !to_flag && !crc_flag && !rsp_flag, "R11 abort to idle", busy, 0);
    enable = 1'b1;
  endtask

  initial begin
    idle_wait(3);
    t_reset_and_gap();
    t_response();
    t_timeout();
    t_irq_wait();
    t_pend();
    t_crc();
    t_cpl();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule